// File: doc/BRIEF.md
# Register-Driven Atomic Read-Modify-Write Unit

This unit lets software carry out an atomic read-modify-write without dedicated instructions. It works through three memory-mapped registers. A write to the link register names a word in memory, and the unit fetches that word into its value register. Software reads the value, computes a new one and writes the result back to the value register. That write triggers a conditional store to the linked word.

While the link is open, the unit watches for events that would make the update unsafe. These are another master touching the linked word, a bus lock, an interrupt being taken, and a bus error on either memory transfer. Each event sets its own sticky flag in the status register. Software checks the flags after the store has finished. If any flag is set, the sequence failed and memory was not changed by it, so software starts over with a fresh write to the link register. No privileged setup is needed between operations, so user code can drive the whole sequence.

The register port is a single-cycle write strobe with a combinational read path. The memory side is one request that is held until the memory acknowledges it.

Top module: `llsc_unit`

## Requirements
- R1: A write to offset 0x0 while idle loads the link address and starts a memory read of that word. Status bit 4 (busy) is high from the cycle after the write until the read is acknowledged.
- R2: A write to offset 0x0 clears the four watch flags in status bits 3..0.
- R3: After a successful fetch, a read of offset 0x4 returns the fetched memory word.
- R4: A write to offset 0x4 while the link is open and all flags are clear issues one memory write of that value to the link address. Busy stays high until the write is acknowledged, and then the link closes.
- R5: While the link is open, a snoop whose address equals the link address sets status bit 0 (read watch). A snoop to any other address has no effect.
- R6: While the link is open, an asserted lock input sets status bit 1 and an interrupt-taken pulse sets status bit 2. With no link open, neither input has any effect.
- R7: An error response on the fetch or on the store sets status bit 3. A fetch error leaves no link open.
- R8: A write to offset 0x4 while any flag is set issues no memory write and closes the link.
- R9: A write to offset 0x4 while no link is open issues no memory write and sets status bit 0.
- R10: Register writes made while busy are ignored. This covers both the link address and the value register.
- R11: Watch flags are sticky. Once set, a flag stays set until the next accepted write to offset 0x0.
- R12: The memory request, its address, direction and write data stay unchanged from the cycle they are raised until the acknowledge.
- R13: After reset, all three registers read zero and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| snoop_valid | input | 1 | Another master is accessing memory |
| snoop_addr | input | AW | Address of that access |
| lock_in | input | 1 | Bus lock is asserted |
| irq_taken | input | 1 | An interrupt was taken (pulse) |

## Verification
The hardest case to reach from the ports is an event that lands in the short window after the fetch and before the conditional store. A second case is a register write that arrives while a transfer is still waiting for its acknowledge. The bench uses a memory model with a configurable response latency. It waits for busy to fall, pulses one chosen event at a cycle boundary, and only then writes the value register. Busy-window writes are placed inside a deliberately long fetch. Random rounds vary the address, the event kind, the latency and store errors, and a bench function predicts the status word and the resulting memory contents.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_OPEN,
    ST_STORE
  } llsc_state_e;

  localparam int unsigned FLAG_N   = 4;
  localparam int unsigned W_SNOOP  = 0;
  localparam int unsigned W_LOCK   = 1;
  localparam int unsigned W_IRQ    = 2;
  localparam int unsigned W_BERR   = 3;
  localparam int unsigned STAT_W   = FLAG_N + 1;

  localparam int unsigned OFS_LINK = 'h0;
  localparam int unsigned OFS_VAL  = 'h4;
  localparam int unsigned OFS_STAT = 'h8;

  // any set watch flag means the sequence is broken
  function automatic logic any_watch(input logic [FLAG_N-1:0] f);
    return |f;
  endfunction

  // status layout: busy above the flags
  function automatic logic [STAT_W-1:0] status_word(input logic busy,
                                                    input logic [FLAG_N-1:0] f);
    return {busy, f};
  endfunction

endpackage

// File: rtl/llsc_seq.sv
module llsc_seq
  import llsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          abort,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] link_addr,
  output logic [DW-1:0] data_q,
  output logic          busy,
  output logic          link_open,
  output logic          xfer_err,
  output logic          nolink_wr
);

  llsc_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      link_addr <= '0;
      data_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_OPEN: begin
          if (addr_wr) begin
            link_addr <= wdata[AW-1:0];
            state     <= ST_FETCH;
          end else if (data_wr) begin
            data_q <= wdata;
            state  <= (state == ST_OPEN && !abort) ? ST_STORE : ST_IDLE;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (!mem_err) data_q <= mem_rdata;
            state <= mem_err ? ST_IDLE : ST_OPEN;
          end
        end
        ST_STORE: begin
          if (mem_ack) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_FETCH) || (state == ST_STORE);
  assign link_open = (state == ST_FETCH) || (state == ST_OPEN);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_STORE);
  assign mem_addr  = link_addr;
  assign mem_wdata = data_q;
  assign xfer_err  = busy && mem_ack && mem_err;
  assign nolink_wr = data_wr && (state == ST_IDLE);

endmodule

// File: rtl/llsc_watch.sv
module llsc_watch
  import llsc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              watch_en,
  input  logic              snoop_valid,
  input  logic [AW-1:0]     snoop_addr,
  input  logic [AW-1:0]     link_addr,
  input  logic              lock_in,
  input  logic              irq_in,
  input  logic              berr,
  input  logic              nolink,
  output logic [FLAG_N-1:0] flags
);

  logic [FLAG_N-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[W_SNOOP] = (watch_en && snoop_valid && (snoop_addr == link_addr)) || nolink;
    set_vec[W_LOCK]  = watch_en && lock_in;
    set_vec[W_IRQ]   = watch_en && irq_in;
    set_vec[W_BERR]  = berr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flags <= '0;
    else if (clear) flags <= '0;
    else            flags <= flags | set_vec;
  end

endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
  import llsc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              snoop_valid,
  input  logic [AW-1:0]     snoop_addr,
  input  logic              lock_in,
  input  logic              irq_taken
);

  localparam logic [REG_AW-1:0] A_LINK = REG_AW'(OFS_LINK);
  localparam logic [REG_AW-1:0] A_VAL  = REG_AW'(OFS_VAL);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);

  // named internal events, observed by the bound checker
  logic              busy;
  logic              link_open;
  logic              addr_wr;
  logic              data_wr;
  logic              xfer_err;
  logic              nolink_wr;
  logic [AW-1:0]     link_addr;
  logic [DW-1:0]     data_q;
  logic [FLAG_N-1:0] flags;

  assign addr_wr = reg_en && reg_we && !busy && (reg_addr == A_LINK);
  assign data_wr = reg_en && reg_we && !busy && (reg_addr == A_VAL);

  llsc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_wr   (addr_wr),
    .data_wr   (data_wr),
    .wdata     (reg_wdata),
    .abort     (any_watch(flags)),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .link_addr (link_addr),
    .data_q    (data_q),
    .busy      (busy),
    .link_open (link_open),
    .xfer_err  (xfer_err),
    .nolink_wr (nolink_wr)
  );

  llsc_watch #(.AW(AW)) u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (addr_wr),
    .watch_en    (link_open),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .link_addr   (link_addr),
    .lock_in     (lock_in),
    .irq_in      (irq_taken),
    .berr        (xfer_err),
    .nolink      (nolink_wr),
    .flags       (flags)
  );

  always_comb begin
    unique case (reg_addr)
      A_LINK:  reg_rdata = DW'(link_addr);
      A_VAL:   reg_rdata = data_q;
      A_STAT:  reg_rdata = DW'(status_word(busy, flags));
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/llsc_unit_chk.sv
module llsc_unit_chk
  import llsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              irq_taken,
  input logic              busy,
  input logic              link_open,
  input logic              addr_wr,
  input logic              data_wr,
  input logic [AW-1:0]     link_addr,
  input logic [FLAG_N-1:0] flags
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  store_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> flags == '0);

  // R2
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> flags == '0);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(link_addr));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> (flags & $past(flags)) == $past(flags));

  // R7
  berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> flags[W_BERR]);

  // R6
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_open && irq_taken && !addr_wr |=> flags[W_IRQ]);

  // R9
  nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !link_open |=> flags[W_SNOOP] && !mem_req);

endmodule

bind llsc_unit llsc_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .irq_taken (irq_taken),
  .busy      (busy),
  .link_open (link_open),
  .addr_wr   (addr_wr),
  .data_wr   (data_wr),
  .link_addr (link_addr),
  .flags     (flags)
);

// File: tb/llsc_unit_bench.sv
module llsc_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int REG_AW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_en = 1'b0;
  logic              reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [DW-1:0]     reg_wdata = '0;
  logic [DW-1:0]     reg_rdata;
  logic              mem_req;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic              mem_ack = 1'b0;
  logic              mem_err = 1'b0;
  logic [DW-1:0]     mem_rdata = '0;
  logic              snoop_valid = 1'b0;
  logic [AW-1:0]     snoop_addr = '0;
  logic              lock_in = 1'b0;
  logic              irq_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int wait_cnt = 0;
  int wr_count = 0;
  bit err_next = 1'b0;
  logic [DW-1:0] model [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_unit #(.AW(AW), .DW(DW), .REG_AW(REG_AW)) u_llsc_unit (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .lock_in(lock_in), .irq_taken(irq_taken)
  );

  // memory model: acknowledges after lat_cfg waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat_cfg) begin
        mem_ack   = 1'b1;
        mem_err   = err_next;
        mem_rdata = model[mem_addr[3:0]];
        if (mem_we) begin
          wr_count++;
          if (!err_next) model[mem_addr[3:0]] = mem_wdata;
        end
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // expected status after one round: ev 0 none, 1 snoop same, 2 snoop other, 3 lock, 4 irq
  function automatic logic [31:0] exp_status(input int ev, input bit serr);
    logic [31:0] s;
    case (ev)
      1: s = 32'h1;
      3: s = 32'h2;
      4: s = 32'h4;
      default: s = 32'h0;
    endcase
    if (s == 0 && serr) s = 32'h8;
    return s;
  endfunction

  function automatic bit store_lands(input int ev, input bit serr);
    return exp_status(ev, serr) == 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = REG_AW'(ofs); reg_wdata = v;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] v);
    reg_addr = REG_AW'(ofs);
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 60; i++) begin
      rd(8, s);
      if (!s[4]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_event(input int ev, input logic [31:0] a);
    @(negedge clk);
    case (ev)
      1: begin snoop_valid = 1'b1; snoop_addr = a; end
      2: begin snoop_valid = 1'b1; snoop_addr = (a + 1) & 32'hF; end
      3: lock_in = 1'b1;
      4: irq_taken = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    snoop_valid = 1'b0; lock_in = 1'b0; irq_taken = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int wc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 32'h100 * i + 32'h11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(0, v); chk("R13 link", v, 0);
    rd(4, v); chk("R13 value", v, 0);
    rd(8, v); chk("R13 status", v, 0);
    chk("R13 req", {31'b0, mem_req}, 0);

    // R1 R3 R4 plain sequence
    lat_cfg = 2;
    wr(0, 3);
    rd(8, v); chk("R1 busy", v, 32'h10);
    wait_idle();
    rd(4, v); chk("R3 fetched", v, model[3]);
    wr(4, 32'hCAFE0003);
    rd(8, v); chk("R4 busy store", v, 32'h10);
    wait_idle();
    rd(8, v); chk("R4 status", v, 0);
    chk("R4 memory", model[3], 32'hCAFE0003);

    // R6 no link: lock and irq ignored
    pulse_event(3, 0); pulse_event(4, 0);
    rd(8, v); chk("R6 no link", v, 0);

    // R5 other address ignored, same address flags; R8 no store; R11 sticky
    wr(0, 5); wait_idle();
    pulse_event(2, 5);
    rd(8, v); chk("R5 other addr", v, 0);
    pulse_event(1, 5);
    rd(8, v); chk("R5 same addr", v, 1);
    repeat (3) @(negedge clk);
    pulse_event(4, 5);
    rd(8, v); chk("R11 sticky", v, 5);
    wc = wr_count;
    wr(4, 32'hBAD);
    wait_idle();
    chk("R8 no write", wr_count, wc);
    chk("R8 memory", model[5], 32'h511);
    rd(8, v); chk("R8 status", v, 5);

    // R2 clear on link write
    wr(0, 6); wait_idle();
    rd(8, v); chk("R2 cleared", v, 0);
    // R6 lock during link
    pulse_event(3, 6);
    rd(8, v); chk("R6 lock", v, 2);

    // R7 fetch error, then R9 value write with no link
    err_next = 1'b1;
    wr(0, 2); wait_idle();
    err_next = 1'b0;
    rd(8, v); chk("R7 fetch err", v, 8);
    wc = wr_count;
    wr(4, 32'h1234);
    wait_idle();
    rd(8, v); chk("R9 no link status", v, 9);
    chk("R9 no write", wr_count, wc);

    // R7 store error leaves memory unchanged
    wr(0, 7); wait_idle();
    err_next = 1'b1;
    wr(4, 32'h7777);
    wait_idle();
    err_next = 1'b0;
    rd(8, v); chk("R7 store err", v, 8);
    chk("R7 memory", model[7], 32'h711);

    // R10 and R12: writes during a long fetch
    lat_cfg = 6;
    wr(0, 9);
    chk("R12 held req", {31'b0, mem_req}, 1);
    chk("R12 held addr", mem_addr, 9);
    wr(0, 10);
    wr(4, 32'hDEAD);
    chk("R12 still held", mem_addr, 9);
    wait_idle();
    rd(0, v); chk("R10 link kept", v, 9);
    rd(4, v); chk("R10 value kept", v, model[9]);

    // random rounds
    for (int n = 0; n < 40; n++) begin
      int a, ev;
      bit serr;
      logic [31:0] old, nv;
      a = int'($urandom % 16);
      ev = int'($urandom % 5);
      serr = ($urandom % 4) == 0;
      lat_cfg = int'($urandom % 3);
      old = model[a];
      nv = $urandom;
      wr(0, a); wait_idle();
      rd(4, v); chk("R3 random fetch", v, old);
      pulse_event(ev, a);
      err_next = serr;
      wr(4, nv);
      wait_idle();
      err_next = 1'b0;
      rd(8, v); chk("R5 random status", v, exp_status(ev, serr));
      chk("R4 random memory", model[a], store_lands(ev, serr) ? nv : old);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule